// File: doc/BRIEF.md
# Dual-Function Bridge Configuration Register File

This block holds the byte-wide configuration registers of a bridge that exposes two functions. Function 0 is a type-0 host bridge and function 1 is a type-1 PCI-to-PCI bridge. A requester presents a function number, an 8-bit register offset, a write enable and write data in one cycle. Read data comes back from a register on the following clock edge. Each function applies its own write policy to each offset. An offset can be protected, partly masked, write-one-to-clear, or limited to its high nibble. Any other writable offset stores the whole byte.

Reset loads a fixed set of default values in both functions. Bytes 0x00–0x03 of both functions hold the same identification constants, and no write can change them. A function number other than 0 or 1 is not implemented: reads from it return all ones and writes to it are discarded. The block does not decode configuration cycles on the bus. It does not act on the register contents; for example, a write to a memory-shadowing byte only stores the byte.

Top module: `cfg_space_dual`

## Requirements
- R1: After reset, function 0 reads 0x06 at offset 0x04, 0x08 at 0x10, 0xA0 at 0x34, 0x01 at each of 0x56–0x5F, 0xEC at 0x64–0x66, and 0x01 at 0x67 and 0x6B. Every other offset at or above 0x04 reads 0x00.
- R2: After reset, function 1 reads command 0x07 (offset 0x04), status 0x0220 (offsets 0x06/0x07, low byte first), 0x04 at 0x0A, 0x06 at 0x0B, header type 0x01 at 0x0E, 0xF0 at 0x1C, and 0xFFF0 at both 0x20/0x21 and 0x24/0x25. Every other offset at or above 0x04 reads 0x00.
- R3: In both functions, offsets 0x00–0x03 read VENDOR_ID low byte, VENDOR_ID high byte, DEVICE_ID low byte and DEVICE_ID high byte, in that order. Writes to these offsets have no effect.
- R4: Function 0 discards writes to offsets 0x05–0x06, 0x08–0x0C, 0x0E–0x11, 0x14–0x4F, 0x79–0x7D, 0x85–0x87, 0x8C–0xA7 and 0xAD–0xFC.
- R5: At function 0 offset 0x04, a write changes only bit 6. At function 0 offset 0x07, a write clears each bit that is set in both the written value and 0xB0, and leaves all other bits unchanged.
- R6: Function 0 offset 0x12 stores the written value ANDed with 0xF0. Offset 0x13 stores the full byte.
- R7: Function 1 discards writes to offsets 0x05–0x06, 0x08–0x17, 0x1B, 0x1E–0x1F, 0x28–0x3D and 0x43–0xFF.
- R8: At function 1 offset 0x04, a write changes only the bits in mask 0x47. At function 1 offset 0x07, a write clears each bit that is set in both the written value and 0x30.
- R9: Function 1 offsets 0x20, 0x22, 0x24 and 0x26 store the written value ANDed with 0xF0.
- R10: A read with a function number other than 0 or 1 returns 0xFF. A write with such a function number changes no register in either function.
- R11: Any writable offset of either function that has no other rule stores the full written byte.
- R12: Read data appears on rsp_rdata at the clock edge that follows the read request and holds until the next read. A read that follows a write on the next cycle returns the written result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_en | input | 1 | Request valid this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_func | input | FUNC_W | Function number |
| req_off | input | 8 | Register byte offset |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with its default FUNC_W of 3. With that value, six unimplemented function numbers sit beside the two real ones, and all 8 × 256 function/offset pairs can be swept one by one. The sweep first reads every pair after reset. It then applies several write patterns to every pair (all ones, all zeros and offset-dependent values) and reads back the whole space after each pattern. As a result, each protected range, masked byte, clear-on-one byte and nibble-limited byte is checked against an arithmetic model at both of its edges. Directed sequences then check that read data holds across writes and idle cycles, and that a read issued right after a write returns the new value.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

    localparam int BYTE_W   = 8;
    localparam int OFF_W    = 8;
    localparam int NUM_REGS = 1 << OFF_W;
    localparam int NUM_FN   = 2;

    // Per-offset write behaviour
    typedef enum logic [1:0] {
        WP_LOCK  = 2'd0,   // write discarded
        WP_STORE = 2'd1,   // new = wdata & mask
        WP_MERGE = 2'd2,   // new = (old & ~mask) | (wdata & mask)
        WP_CLR   = 2'd3    // new = old & ~(wdata & mask)
    } wp_kind_e;

    typedef struct packed {
        wp_kind_e              kind;
        logic [BYTE_W-1:0]     mask;
    } wp_t;

    function automatic logic in_rng(logic [OFF_W-1:0] o, int lo, int hi);
        return (int'(o) >= lo) && (int'(o) <= hi);
    endfunction

    // Offsets protected in the host-bridge function
    function automatic logic host_locked(logic [OFF_W-1:0] o);
        return in_rng(o, 8'h00, 8'h03) || in_rng(o, 8'h05, 8'h06) ||
               in_rng(o, 8'h08, 8'h0C) || in_rng(o, 8'h0E, 8'h11) ||
               in_rng(o, 8'h14, 8'h4F) || in_rng(o, 8'h79, 8'h7D) ||
               in_rng(o, 8'h85, 8'h87) || in_rng(o, 8'h8C, 8'hA7) ||
               in_rng(o, 8'hAD, 8'hFC);
    endfunction

    // Offsets protected in the PCI-to-PCI function
    function automatic logic p2p_locked(logic [OFF_W-1:0] o);
        return in_rng(o, 8'h00, 8'h03) || in_rng(o, 8'h05, 8'h06) ||
               in_rng(o, 8'h08, 8'h17) || (o == 8'h1B) ||
               in_rng(o, 8'h1E, 8'h1F) || in_rng(o, 8'h28, 8'h3D) ||
               in_rng(o, 8'h43, 8'hFF);
    endfunction

    function automatic wp_t host_policy(logic [OFF_W-1:0] o);
        wp_t p;
        p.kind = WP_STORE;
        p.mask = 8'hFF;
        if (host_locked(o)) begin
            p.kind = WP_LOCK;
            p.mask = 8'h00;
        end else begin
            case (o)
                8'h04:   begin p.kind = WP_MERGE; p.mask = 8'h40; end
                8'h07:   begin p.kind = WP_CLR;   p.mask = 8'hB0; end
                8'h12:   begin p.kind = WP_STORE; p.mask = 8'hF0; end
                default: ;
            endcase
        end
        return p;
    endfunction

    function automatic wp_t p2p_policy(logic [OFF_W-1:0] o);
        wp_t p;
        p.kind = WP_STORE;
        p.mask = 8'hFF;
        if (p2p_locked(o)) begin
            p.kind = WP_LOCK;
            p.mask = 8'h00;
        end else begin
            case (o)
                8'h04:   begin p.kind = WP_MERGE; p.mask = 8'h47; end
                8'h07:   begin p.kind = WP_CLR;   p.mask = 8'h30; end
                8'h20, 8'h22,
                8'h24, 8'h26:
                         begin p.kind = WP_STORE; p.mask = 8'hF0; end
                default: ;
            endcase
        end
        return p;
    endfunction

    function automatic wp_t fn_policy(int fid, logic [OFF_W-1:0] o);
        return (fid == 0) ? host_policy(o) : p2p_policy(o);
    endfunction

    function automatic logic [BYTE_W-1:0] id_byte(logic [OFF_W-1:0] o,
                                                  logic [15:0] vid,
                                                  logic [15:0] did);
        case (o[1:0])
            2'd0:    return vid[7:0];
            2'd1:    return vid[15:8];
            2'd2:    return did[7:0];
            default: return did[15:8];
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] host_default(logic [OFF_W-1:0] o);
        if (in_rng(o, 8'h56, 8'h5F)) return 8'h01;
        if (in_rng(o, 8'h64, 8'h66)) return 8'hEC;
        case (o)
            8'h04:        return 8'h06;
            8'h10:        return 8'h08;
            8'h34:        return 8'hA0;
            8'h67, 8'h6B: return 8'h01;
            default:      return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] p2p_default(logic [OFF_W-1:0] o);
        case (o)
            8'h04:        return 8'h07;
            8'h06:        return 8'h20;
            8'h07:        return 8'h02;
            8'h0A:        return 8'h04;
            8'h0B:        return 8'h06;
            8'h0E:        return 8'h01;
            8'h1C:        return 8'hF0;
            8'h20, 8'h24: return 8'hF0;
            8'h21, 8'h25: return 8'hFF;
            default:      return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] fn_default(int fid,
                                                     logic [OFF_W-1:0] o,
                                                     logic [15:0] vid,
                                                     logic [15:0] did);
        if (o < 8'h04) return id_byte(o, vid, did);
        return (fid == 0) ? host_default(o) : p2p_default(o);
    endfunction

endpackage

// File: rtl/cfg_byte_merge.sv
module cfg_byte_merge
    import cfg_space_pkg::*;
(
    input  wp_t               pol,
    input  logic [BYTE_W-1:0] old_byte,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] new_byte
);

    always_comb begin
        unique case (pol.kind)
            WP_LOCK:  new_byte = old_byte;
            WP_STORE: new_byte = wdata & pol.mask;
            WP_MERGE: new_byte = (old_byte & ~pol.mask) | (wdata & pol.mask);
            WP_CLR:   new_byte = old_byte & ~(wdata & pol.mask);
            default:  new_byte = old_byte;
        endcase
    end

endmodule

// File: rtl/cfg_fn_bank.sv
module cfg_fn_bank
    import cfg_space_pkg::*;
#(
    parameter int          FUNC_ID   = 0,
    parameter logic [15:0] VENDOR_ID = 16'h1D5A,
    parameter logic [15:0] DEVICE_ID = 16'h0C7B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_byte
);

    typedef struct packed {
        logic [NUM_REGS-1:0][BYTE_W-1:0] mem;
    } bank_st_t;

    bank_st_t          st_d, st_q;
    wp_t               pol;
    logic [BYTE_W-1:0] merged;

    assign pol = fn_policy(FUNC_ID, off);

    cfg_byte_merge u_merge (
        .pol      (pol),
        .old_byte (st_q.mem[off]),
        .wdata    (wdata),
        .new_byte (merged)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[off] = merged;
        end
        rd_byte = st_q.mem[off];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                st_q.mem[i] <= fn_default(FUNC_ID, OFF_W'(i), VENDOR_ID, DEVICE_ID);
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cfg_space_dual.sv
module cfg_space_dual
    import cfg_space_pkg::*;
#(
    parameter int          FUNC_W    = 3,
    parameter logic [15:0] VENDOR_ID = 16'h1D5A,
    parameter logic [15:0] DEVICE_ID = 16'h0C7B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic              req_wr,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [BYTE_W-1:0] req_wdata,
    output logic [BYTE_W-1:0] rsp_rdata
);

    localparam logic [BYTE_W-1:0] ABSENT_BYTE = '1;

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } rsp_st_t;

    rsp_st_t                       rs_d, rs_q;
    logic [NUM_FN-1:0][BYTE_W-1:0] fn_rd;
    logic                          fn_hit;

    assign fn_hit = (req_func < FUNC_W'(NUM_FN));

    for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
        logic fn_wr;
        assign fn_wr = req_en && req_wr && (req_func == FUNC_W'(g));

        cfg_fn_bank #(
            .FUNC_ID   (g),
            .VENDOR_ID (VENDOR_ID),
            .DEVICE_ID (DEVICE_ID)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (fn_wr),
            .off     (req_off),
            .wdata   (req_wdata),
            .rd_byte (fn_rd[g])
        );
    end

    always_comb begin
        rs_d = rs_q;
        if (req_en && !req_wr) begin
            rs_d.rdata = fn_hit ? fn_rd[req_func[0]] : ABSENT_BYTE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rsp_rdata = rs_q.rdata;

endmodule

// File: rtl/cfg_space_dual_chk.sv
module cfg_space_dual_chk #(
    parameter int          FUNC_W    = 3,
    parameter logic [15:0] VENDOR_ID = 16'h1D5A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_en,
    input logic              req_wr,
    input logic [FUNC_W-1:0] req_func,
    input logic [7:0]        req_off,
    input logic [7:0]        rsp_rdata
);

    logic rd_req;
    assign rd_req = req_en && !req_wr;

    a_r10_absent_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_func >= FUNC_W'(2)) |=> (rsp_rdata == 8'hFF));

    a_r3_vendor_low_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_func < FUNC_W'(2) && req_off == 8'h00) |=> (rsp_rdata == VENDOR_ID[7:0]));

    a_r5_host_cmd_only_bit6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_func == FUNC_W'(0) && req_off == 8'h04) |=> ((rsp_rdata & 8'hBF) == 8'h06));

    a_r8_p2p_cmd_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_func == FUNC_W'(1) && req_off == 8'h04) |=> ((rsp_rdata & 8'hB8) == 8'h00));

    a_r9_p2p_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_func == FUNC_W'(1) && req_off == 8'h20) |=> (rsp_rdata[3:0] == 4'h0));

    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rsp_rdata));

endmodule

bind cfg_space_dual cfg_space_dual_chk #(
    .FUNC_W    (FUNC_W),
    .VENDOR_ID (VENDOR_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_en    (req_en),
    .req_wr    (req_wr),
    .req_func  (req_func),
    .req_off   (req_off),
    .rsp_rdata (rsp_rdata)
);

// File: tb/cfg_space_dual_tb.sv
`timescale 1ns/1ps
module cfg_space_dual_tb;

    localparam int          FW  = 3;
    localparam logic [15:0] VID = 16'h1D5A;
    localparam logic [15:0] DID = 16'h0C7B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_en = 1'b0;
    logic       req_wr = 1'b0;
    logic [FW-1:0] req_func = '0;
    logic [7:0] req_off = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [0:1][0:255];

    always #2 clk = ~clk;

    cfg_space_dual #(.FUNC_W(FW), .VENDOR_ID(VID), .DEVICE_ID(DID)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
        .req_func(req_func), .req_off(req_off), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata)
    );

    function automatic bit between(int o, int lo, int hi);
        return o >= lo && o <= hi;
    endfunction

    function automatic bit ro0(int o);
        return between(o,0,3) || between(o,5,6) || between(o,8,12) || between(o,14,17) ||
               between(o,20,79) || between(o,121,125) || between(o,133,135) ||
               between(o,140,167) || between(o,173,252);
    endfunction

    function automatic bit ro1(int o);
        return between(o,0,3) || between(o,5,6) || between(o,8,23) || o == 27 ||
               between(o,30,31) || between(o,40,61) || o >= 67;
    endfunction

    function automatic logic [7:0] dflt(int f, int o);
        logic [15:0] w;
        if (o < 4) begin
            w = (o < 2) ? VID : DID;
            return (o % 2 == 0) ? w[7:0] : w[15:8];
        end
        if (f == 0) begin
            if (o == 4) return 8'h06;
            if (o == 16) return 8'h08;
            if (o == 52) return 8'hA0;
            if (between(o,86,95) || o == 103 || o == 107) return 8'h01;
            if (between(o,100,102)) return 8'hEC;
            return 8'h00;
        end
        case (o)
            4: return 8'h07;
            6: return 8'h20;
            7: return 8'h02;
            10: return 8'h04;
            11: return 8'h06;
            14: return 8'h01;
            28, 32, 36: return 8'hF0;
            33, 37: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag(int f, int o);
        if (f > 1) return "R10";
        if (o < 4) return "R3";
        if (f == 0) begin
            if (o == 4 || o == 7) return "R5";
            if (o == 18 || o == 19) return "R6";
            if (ro0(o)) return "R4";
            return "R11";
        end
        if (o == 4 || o == 7) return "R8";
        if (o == 32 || o == 34 || o == 36 || o == 38) return "R9";
        if (ro1(o)) return "R7";
        return "R11";
    endfunction

    task automatic model_write(int f, int o, logic [7:0] v);
        if (f > 1) return;
        if (f == 0) begin
            if (ro0(o)) return;
            if (o == 4) model[0][o] = (model[0][o] & 8'hBF) | (v & 8'h40);
            else if (o == 7) model[0][o] = model[0][o] & ~(v & 8'hB0);
            else if (o == 18) model[0][o] = v & 8'hF0;
            else model[0][o] = v;
        end else begin
            if (ro1(o)) return;
            if (o == 4) model[1][o] = (model[1][o] & 8'hB8) | (v & 8'h47);
            else if (o == 7) model[1][o] = model[1][o] & ~(v & 8'h30);
            else if (o == 32 || o == 34 || o == 36 || o == 38) model[1][o] = v & 8'hF0;
            else model[1][o] = v;
        end
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic do_write(int f, int o, logic [7:0] v);
        @(negedge clk);
        req_en = 1'b1; req_wr = 1'b1; req_func = FW'(f); req_off = 8'(o); req_wdata = v;
        @(negedge clk);
        req_en = 1'b0; req_wr = 1'b0;
        model_write(f, o, v);
    endtask

    task automatic do_read(int f, int o, output logic [7:0] r);
        @(negedge clk);
        req_en = 1'b1; req_wr = 1'b0; req_func = FW'(f); req_off = 8'(o);
        @(negedge clk);
        req_en = 1'b0;
        r = rsp_rdata;
    endtask

    task automatic sweep_read(string phase);
        logic [7:0] r;
        for (int f = 0; f < 8; f++) begin
            for (int o = 0; o < 256; o++) begin
                do_read(f, o, r);
                check(tag(f, o), r, (f > 1) ? 8'hFF : model[f][o],
                      $sformatf("%s f%0d off %02h", phase, f, o));
            end
        end
    endtask

    task automatic sweep_write(int pat);
        for (int f = 0; f < 8; f++) begin
            for (int o = 0; o < 256; o++) begin
                logic [7:0] v;
                case (pat)
                    0: v = 8'hFF;
                    1: v = 8'h00;
                    2: v = 8'((o * 7 + f * 3) ^ 8'h5A);
                    default: v = 8'hA5;
                endcase
                do_write(f, o, v);
            end
        end
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        for (int f = 0; f < 2; f++)
            for (int o = 0; o < 256; o++)
                model[f][o] = dflt(f, o);
        repeat (3) @(negedge clk);
        check("R12", rsp_rdata, 8'h00, "rdata at reset");
        rst_n = 1'b1;

        // R1 R2 R10: reset image of all function numbers
        for (int f = 0; f < 8; f++) begin
            for (int o = 0; o < 256; o++) begin
                do_read(f, o, r);
                check((f > 1) ? "R10" : (f == 0 ? "R1" : "R2"), r,
                      (f > 1) ? 8'hFF : model[f][o], $sformatf("reset f%0d off %02h", f, o));
            end
        end

        for (int p = 0; p < 4; p++) begin
            sweep_write(p);
            sweep_read($sformatf("pattern%0d", p));
        end

        // R12: data holds across a write and idle cycles
        do_read(0, 52, r);
        check("R12", r, model[0][52], "read f0 0x34");
        @(negedge clk);
        req_en = 1'b1; req_wr = 1'b1; req_func = FW'(1); req_off = 8'h40; req_wdata = 8'h3C;
        @(negedge clk);
        req_en = 1'b0; req_wr = 1'b0;
        model_write(1, 64, 8'h3C);
        check("R12", rsp_rdata, model[0][52], "hold during write");
        @(negedge clk);
        check("R12", rsp_rdata, model[0][52], "hold during idle");
        do_read(1, 64, r);
        check("R12", r, 8'h3C, "read right after write");

        // R3: identification bytes after writes
        for (int o = 0; o < 4; o++) begin
            do_write(1, o, 8'h00);
            do_read(1, o, r);
            check("R3", r, dflt(1, o), $sformatf("id byte %0d", o));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule